// File: doc/BRIEF.md
# ADC Sequencer Status Register

This block holds the status word of a multi-channel analog-to-digital conversion sequencer. The sequencer reports events to it as single-cycle strobes: a conversion has finished, a sequence has finished, an external trigger edge has arrived, an external trigger has started a sequence, or a sequence has been aborted. The block also sees host writes to the control registers and to the status register, host reads of the result registers, and four mode bits. From these it keeps three sticky flags and a 3-bit conversion counter, and it presents them as one 8-bit read-only status word.

The counter selects which of eight result slots receives the current conversion. The block keeps its own "slot holds unread data" bit for each slot. It uses these bits to detect a result that is overwritten before the host has read it. Each flag has its own set event and its own list of clear events. When a set and a clear for the same flag fall in the same cycle, the set wins.

Every status bit comes straight from a register. A host read therefore sees the effect of an event one clock after the cycle in which the strobe was high. All inputs are plain single-cycle control pins, so the block has no data stream and no back-pressure.

Top module: `adc_seq_status`

## Requirements
- R1: After reset, `status_o` is 0x00. Bits 6 and 3 always read as 0. The bit positions are: bit 7 sequence-complete, bit 5 trigger overrun, bit 4 result overrun, bits 2:0 counter.
- R2: A `seq_done_i` strobe sets the sequence-complete flag. In scan mode it sets again after every completed sequence.
- R3: The sequence-complete flag clears on any of three events: a status write (`host_sel_i`=4) with data bit 7 = 1; a write to the start register (`host_sel_i`=3); a result read when `fast_clr_i`=1. A result read with `fast_clr_i`=0 leaves the flag set.
- R4: The trigger overrun flag sets only when all of these hold: `edge_trig_i`=1, `trig_edge_i` is high, and a sequence is in progress. A sequence is in progress from a start write or `seq_start_i` until `seq_done_i` with scan off, an abort, or a configuration write. Outside edge mode, or while idle, edges have no effect.
- R5: The trigger overrun flag clears on any of three events: a status write with data bit 5 = 1; a write to any configuration register (`host_sel_i` = 0, 1 or 2); a start write.
- R6: A `conv_done_i` strobe marks the slot the counter points at as holding data. A host read of a slot clears its mark. Start writes, configuration writes and aborts clear all marks. A `conv_done_i` into a slot that is already marked sets the result overrun flag.
- R7: The result overrun flag clears on a status write with data bit 4 = 1, on a start write, or on `seq_start_i`.
- R8: Each `conv_done_i` advances the counter by one, and the counter wraps from 7 to 0.
- R9: When `fifo_mode_i`=0, the counter returns to 0 on `seq_start_i` and on `seq_done_i`. When `fifo_mode_i`=1, neither strobe changes the counter.
- R10: An `abort_i` strobe or any control write (`host_sel_i` 0 to 3) zeroes the counter, even in FIFO mode. A status write never changes the counter.
- R11: If a set event and a clear event for the same flag occur in the same cycle, the flag ends set.
- R12: Writing 0 to a flag bit of the status word leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done_i | input | 1 | One conversion finished; its result is written to the current slot |
| seq_done_i | input | 1 | Conversion sequence finished |
| trig_edge_i | input | 1 | Active external trigger edge seen |
| seq_start_i | input | 1 | Sequence started by an external trigger |
| abort_i | input | 1 | Sequence aborted by the sequencer |
| host_wr_i | input | 1 | Host register write strobe |
| host_sel_i | input | 3 | Register written: 0-2 configuration, 3 start, 4 status, 5-7 none |
| host_wdata_i | input | 8 | Host write data |
| host_rd_i | input | 1 | Host read of a result slot |
| host_rd_idx_i | input | 3 | Index of the result slot being read |
| fifo_mode_i | input | 1 | FIFO mode: the counter keeps its value across sequences |
| scan_mode_i | input | 1 | Continuous scan mode |
| edge_trig_i | input | 1 | External trigger is edge sensitive |
| fast_clr_i | input | 1 | A result read clears the sequence-complete flag |
| status_o | output | 8 | Status word |

## Verification
On every cycle, the assertions check four rules:
- the sequence-complete flag sets after each sequence-done strobe;
- the trigger overrun flag can only rise from an edge in edge mode;
- configuration writes clear the overrun and zero the counter;
- the counter steps by one or holds across status writes, as the mode requires.

The per-slot overwrite detection needs a scenario to show it, because it depends on hidden slot state built up over several events. The same holds for the in-progress window that gates trigger overrun, for the FIFO wrap across sequences, for set-over-clear priority, and for the no-effect behaviour of zero writes and reads with fast-clear off. The bench covers these with directed sequences.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_SCF  = 7;
  localparam int BIT_TOVR = 5;
  localparam int BIT_ROVR = 4;

  typedef enum logic [2:0] {
    SEL_CFG0  = 3'd0,
    SEL_CFG1  = 3'd1,
    SEL_CFG2  = 3'd2,
    SEL_START = 3'd3,
    SEL_STAT  = 3'd4
  } host_sel_e;
endpackage

// File: rtl/adc_sticky_flag.sv
module adc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set dominates clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/adc_conv_counter.sv
module adc_conv_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_i,
  input  logic             force_zero_i,
  input  logic             seq_bound_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_o;
    if (force_zero_i)               cnt_nxt = '0;
    else if (!fifo_i && seq_bound_i) cnt_nxt = '0;
    else if (inc_i)                 cnt_nxt = cnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_nxt;
  end
endmodule

// File: rtl/adc_slot_tracker.sv
module adc_slot_tracker #(
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             clr_all_i,
  output logic             ovr_o
);
  logic [SLOTS-1:0] full_q;

  assign ovr_o = wr_i && full_q[wr_idx_i];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  full_q[s] <= 1'b0;
      else if (clr_all_i)                          full_q[s] <= 1'b0;
      else if (wr_i && wr_idx_i == IDX_W'(s))      full_q[s] <= 1'b1;
      else if (rd_i && rd_idx_i == IDX_W'(s))      full_q[s] <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
  import adc_stat_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int CNT_W = $clog2(SLOTS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        conv_done_i,
  input  logic        seq_done_i,
  input  logic        trig_edge_i,
  input  logic        seq_start_i,
  input  logic        abort_i,
  input  logic        host_wr_i,
  input  logic [2:0]  host_sel_i,
  input  logic [7:0]  host_wdata_i,
  input  logic        host_rd_i,
  input  logic [2:0]  host_rd_idx_i,
  input  logic        fifo_mode_i,
  input  logic        scan_mode_i,
  input  logic        edge_trig_i,
  input  logic        fast_clr_i,
  output logic [7:0]  status_o
);
  logic wr_cfg, wr_start, wr_stat;
  logic busy_q;
  logic scf, tovr, rovr, slot_ovr;
  logic [CNT_W-1:0] cnt;

  assign wr_cfg   = host_wr_i && (host_sel_i == SEL_CFG0 || host_sel_i == SEL_CFG1 ||
                                  host_sel_i == SEL_CFG2);
  assign wr_start = host_wr_i && host_sel_i == SEL_START;
  assign wr_stat  = host_wr_i && host_sel_i == SEL_STAT;

  // sequence-in-progress window used by the trigger overrun check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          busy_q <= 1'b0;
    else if (wr_start || seq_start_i)    busy_q <= 1'b1;
    else if (wr_cfg || abort_i)          busy_q <= 1'b0;
    else if (seq_done_i && !scan_mode_i) busy_q <= 1'b0;
  end

  adc_sticky_flag u_scf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (seq_done_i),
    .clr_i  ((wr_stat && host_wdata_i[BIT_SCF]) || wr_start || (host_rd_i && fast_clr_i)),
    .flag_o (scf)
  );

  adc_sticky_flag u_tovr (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (edge_trig_i && trig_edge_i && busy_q),
    .clr_i  ((wr_stat && host_wdata_i[BIT_TOVR]) || wr_cfg || wr_start),
    .flag_o (tovr)
  );

  adc_sticky_flag u_rovr (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (slot_ovr),
    .clr_i  ((wr_stat && host_wdata_i[BIT_ROVR]) || wr_start || seq_start_i),
    .flag_o (rovr)
  );

  adc_slot_tracker #(.SLOTS(SLOTS)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (conv_done_i),
    .wr_idx_i  (cnt),
    .rd_i      (host_rd_i),
    .rd_idx_i  (host_rd_idx_i[CNT_W-1:0]),
    .clr_all_i (wr_start || wr_cfg || abort_i),
    .ovr_o     (slot_ovr)
  );

  adc_conv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_i       (fifo_mode_i),
    .force_zero_i (abort_i || wr_cfg || wr_start),
    .seq_bound_i  (seq_start_i || seq_done_i),
    .inc_i        (conv_done_i),
    .cnt_o        (cnt)
  );

  always_comb begin
    status_o           = '0;
    status_o[BIT_SCF]  = scf;
    status_o[BIT_TOVR] = tovr;
    status_o[BIT_ROVR] = rovr;
    status_o[CNT_W-1:0] = cnt;
  end
endmodule

// File: rtl/adc_seq_status_chk.sv
module adc_seq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_done_i,
  input logic       seq_done_i,
  input logic       trig_edge_i,
  input logic       seq_start_i,
  input logic       abort_i,
  input logic       host_wr_i,
  input logic [2:0] host_sel_i,
  input logic       fifo_mode_i,
  input logic       edge_trig_i,
  input logic [7:0] status_o
);
  logic ctl_wr;
  assign ctl_wr = host_wr_i && host_sel_i <= 3'd3;

  a_r2_scf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_i |=> status_o[7]);

  a_r4_tovr_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[5]) |-> $past(edge_trig_i && trig_edge_i));

  a_r5_cfg_clears_tovr: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_i && host_sel_i <= 3'd2 && !trig_edge_i) |=> !status_o[5]);

  a_r10_ctl_zeroes_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr || abort_i) |=> status_o[2:0] == 3'd0);

  a_r10_stat_wr_keeps_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_i && host_sel_i == 3'd4 && !conv_done_i && !abort_i && !seq_done_i && !seq_start_i)
    |=> $stable(status_o[2:0]));

  a_r8_cnt_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_i && !abort_i && !ctl_wr && (fifo_mode_i || (!seq_done_i && !seq_start_i)))
    |=> status_o[2:0] == 3'($past(status_o[2:0]) + 3'd1));
endmodule

bind adc_seq_status adc_seq_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_done_i (conv_done_i),
  .seq_done_i  (seq_done_i),
  .trig_edge_i (trig_edge_i),
  .seq_start_i (seq_start_i),
  .abort_i     (abort_i),
  .host_wr_i   (host_wr_i),
  .host_sel_i  (host_sel_i),
  .fifo_mode_i (fifo_mode_i),
  .edge_trig_i (edge_trig_i),
  .status_o    (status_o)
);

// File: tb/test_adc_seq_status.sv
module test_adc_seq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done, seq_done, trig_edge, seq_start, abort_s;
  logic       host_wr, host_rd;
  logic [2:0] host_sel, rd_idx;
  logic [7:0] wdata;
  logic       fifo, scan, edge_m, fast;
  logic [7:0] status;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  adc_seq_status i_adc_seq_status (
    .clk(clk), .rst_n(rst_n),
    .conv_done_i(conv_done), .seq_done_i(seq_done), .trig_edge_i(trig_edge),
    .seq_start_i(seq_start), .abort_i(abort_s),
    .host_wr_i(host_wr), .host_sel_i(host_sel), .host_wdata_i(wdata),
    .host_rd_i(host_rd), .host_rd_idx_i(rd_idx),
    .fifo_mode_i(fifo), .scan_mode_i(scan), .edge_trig_i(edge_m), .fast_clr_i(fast),
    .status_o(status)
  );

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (status !== exp) begin
      n_fail++;
      $display("FAIL %s: status actual=%02h expected=%02h", req, status, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    conv_done = 0; seq_done = 0; trig_edge = 0; seq_start = 0; abort_s = 0;
    host_wr = 0; host_rd = 0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    host_wr = 1; host_sel = sel; wdata = d; tick();
  endtask
  task automatic conv();  conv_done = 1; tick(); endtask
  task automatic sdone(); seq_done = 1;  tick(); endtask
  task automatic trig();  trig_edge = 1; tick(); endtask
  task automatic tstart(); seq_start = 1; tick(); endtask
  task automatic rd(input logic [2:0] i); host_rd = 1; rd_idx = i; tick(); endtask

  task automatic t_reset();
    chk("R1 reset", 8'h00);
  endtask

  task automatic t_seq_complete();
    fifo = 0; scan = 0; fast = 0;
    wr(3, 0);
    conv(); conv(); conv();
    chk("R8 count three", 8'h03);
    sdone();
    chk("R2/R9 done sets flag, zeroes count", 8'h80);
    wr(4, 8'h00);
    chk("R12 zero write ignored", 8'h80);
    rd(0);
    chk("R3 read without fast clear", 8'h80);
    fast = 1; rd(1); fast = 0;
    chk("R3 fast clear read", 8'h00);
    sdone(); wr(4, 8'h80);
    chk("R3 write one clears", 8'h00);
    sdone(); wr(3, 0);
    chk("R3 start write clears", 8'h00);
    scan = 1; sdone(); wr(4, 8'h80); sdone();
    chk("R2 scan sets again", 8'h80);
    scan = 0; sdone(); wr(4, 8'h80);
    chk("R1 idle cleared", 8'h00);
  endtask

  task automatic t_trig_overrun();
    edge_m = 1;
    wr(3, 0); trig();
    chk("R4 edge while busy", 8'h20);
    wr(4, 8'h20);
    chk("R5 write one clears", 8'h00);
    trig(); wr(0, 0);
    chk("R5 config write clears", 8'h00);
    trig();
    chk("R4 edge while idle", 8'h00);
    wr(3, 0); trig(); wr(3, 0);
    chk("R5 start write clears", 8'h00);
    edge_m = 0; trig();
    chk("R4 level mode ignores edge", 8'h00);
    edge_m = 1; scan = 1; sdone(); trig();
    chk("R4 scan keeps busy", 8'hA0);
    scan = 0; wr(2, 0); wr(4, 8'hA0);
    chk("R5 cleanup", 8'h00);
    edge_m = 0;
  endtask

  task automatic t_result_overrun();
    fifo = 0;
    wr(3, 0); conv();
    chk("R8 one conversion", 8'h01);
    sdone(); wr(4, 8'h80);
    tstart(); conv();
    chk("R6 overwrite unread slot", 8'h11);
    tstart();
    chk("R7/R9 trigger start clears, zeroes", 8'h00);
    rd(0); conv();
    chk("R6 read slot no overrun", 8'h01);
    tstart(); conv();
    chk("R6 overwrite again", 8'h11);
    wr(4, 8'h10);
    chk("R7/R10 write one clears, count kept", 8'h01);
    tstart(); conv(); wr(3, 0);
    chk("R7 start write clears", 8'h00);
  endtask

  task automatic t_fifo_count();
    fifo = 1;
    wr(3, 0);
    for (int k = 0; k < 9; k++) conv();
    chk("R8 wrap plus overrun", 8'h11);
    sdone();
    chk("R9 fifo keeps count at end", 8'h91);
    tstart();
    chk("R9 fifo keeps count at start", 8'h81);
    wr(4, 8'hFF);
    chk("R10 status write keeps count", 8'h01);
    abort_s = 1; tick();
    chk("R10 abort zeroes in fifo", 8'h00);
    conv();
    chk("R6 abort cleared slots", 8'h01);
    wr(1, 0);
    chk("R10 config write zeroes in fifo", 8'h00);
    fifo = 0;
  endtask

  task automatic t_priority();
    seq_done = 1; host_wr = 1; host_sel = 4; wdata = 8'h80; tick();
    chk("R11 set beats clear", 8'h80);
    wr(4, 8'h80);
    chk("R11 then clears", 8'h00);
  endtask

  initial begin
    conv_done = 0; seq_done = 0; trig_edge = 0; seq_start = 0; abort_s = 0;
    host_wr = 0; host_rd = 0; host_sel = 0; rd_idx = 0; wdata = 0;
    fifo = 0; scan = 0; edge_m = 0; fast = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_seq_complete();
    t_trig_overrun();
    t_result_overrun();
    t_fifo_count();
    t_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule